// File: doc/BRIEF.md
# SDRAM Controller Utilisation and Efficiency Monitor

This block watches an SDRAM controller, which raises per-cycle status strobes. Over a window whose length in clock cycles is set by a configuration input, it counts several things. These are every clock cycle, the cycles in which the controller is busy, the cycles in which read or write data actually moves, the page activations, the bytes transferred and the idle cycles. When the window closes, all running counts are copied into a shadow set and the live counters restart from zero on the same edge. Software reads the shadow set through a small address/data read port. From those values it derives three figures: the busy ratio (busy/total), the efficiency (data cycles/busy cycles) and the average bytes moved per page activation.

Page thrashing sets in when the controller has almost no idle cycles left. For this reason the block also compares the idle count of each closed window against a programmable threshold and raises a saturation flag when the idle count falls short. The ratios themselves are left to software.

Top module: `sdram_perf_monitor`

## Requirements
- R1: The window length is `cfg_window` cycles, with a value of 0 treated as 1. `win_done` is high during the last cycle of each window, and the latched total equals the window length.
- R2: The latched busy count equals the number of window cycles with `mc_busy` high.
- R3: A data cycle is counted only when `mc_xfer` and `mc_busy` are both high. `mc_xfer` without `mc_busy` is ignored, so the data count never exceeds the busy count.
- R4: A page activation is counted only when `mc_open` and `mc_busy` are both high. `mc_open` without `mc_busy` is ignored.
- R5: The byte count is the sum of `mc_bytes` over the counted data cycles of the window. `mc_bytes` on other cycles is ignored.
- R6: The latched idle count equals the number of window cycles with `mc_busy` low, so busy plus idle equals total.
- R7: At each window end, the saturation flag is set when the latched idle count is strictly below `cfg_idle_thresh` and cleared otherwise. A threshold of 0 never sets it. The flag is on `sat_flag` and on bit 0 of register 6.
- R8: The live counters restart from zero on the latch edge, so consecutive windows report only their own events.
- R9: Counters stop at their all-ones value instead of wrapping.
- R10: A read during the latch cycle returns the value being latched on that edge, not the old shadow value.
- R11: After reset, every register reads 0, and `sat_flag` and `win_done` are low for a window longer than one cycle.
- R12: Register addresses on `rd_addr` are: 0 total, 1 busy, 2 data cycles, 3 page activations, 4 bytes, 5 idle, 6 status (bit 0 saturation flag). Address 7 reads 0. Values are zero-extended to the width of `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_window | input | CNT_W | Window length in cycles (0 acts as 1) |
| cfg_idle_thresh | input | CNT_W | Idle-cycle threshold for the saturation flag |
| mc_busy | input | 1 | Controller is not idle this cycle |
| mc_xfer | input | 1 | Read or write data moves this cycle |
| mc_open | input | 1 | A page activation is issued this cycle |
| mc_bytes | input | BEAT_W | Bytes moved this cycle |
| rd_addr | input | 3 | Register select |
| rd_data | output | BYTE_W | Selected register value (combinational) |
| win_done | output | 1 | High in the last cycle of a window |
| sat_flag | output | 1 | Latched saturation flag |

## Verification
The in-module assertions check the following on every cycle:
- The latched total matches the configured window length.
- Data and activation counts never exceed the busy count.
- Busy plus idle equals total.
- The saturation flag agrees with the latched idle count and the threshold sampled at the latch.
- A counter that has reached its limit stays there.

Other behaviours are shown only by the bench's scenarios:
- Strobes without `mc_busy` are ignored.
- The byte sum, including clamping at the limit.
- The read bypass during the latch cycle.
- The strict comparison at a threshold equal to the idle count.
- The clearing between back-to-back windows.

// File: rtl/sdram_perf_monitor.sv
`timescale 1ns/1ps
module sdram_perf_monitor #(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 48,
  parameter int BEAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_window,
  input  logic [CNT_W-1:0]  cfg_idle_thresh,
  input  logic              mc_busy,
  input  logic              mc_xfer,
  input  logic              mc_open,
  input  logic [BEAT_W-1:0] mc_bytes,
  input  logic [2:0]        rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              win_done,
  output logic              sat_flag
);

  localparam logic [CNT_W-1:0]  CMAX = '1;
  localparam logic [BYTE_W-1:0] BMAX = '1;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c, input logic en);
    return (en && c != CMAX) ? c + 1'b1 : c;
  endfunction

  logic [CNT_W-1:0]  tot_q, busy_q, xfer_q, open_q, idle_q;
  logic [CNT_W-1:0]  tot_n, busy_n, xfer_n, open_n, idle_n;
  logic [CNT_W-1:0]  sh_tot, sh_busy, sh_xfer, sh_open, sh_idle;
  logic [BYTE_W-1:0] byt_q, byt_n, sh_byt;
  logic [BYTE_W:0]   byt_sum;
  logic [CNT_W-1:0]  win_len;
  logic              sat_q, sat_n, q_xfer, q_open;

  assign q_xfer  = mc_busy & mc_xfer;
  assign q_open  = mc_busy & mc_open;
  assign win_len = (cfg_window == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : cfg_window;
  assign win_done = (tot_q >= win_len - 1'b1);

  assign tot_n  = bump(tot_q, 1'b1);
  assign busy_n = bump(busy_q, mc_busy);
  assign idle_n = bump(idle_q, !mc_busy);
  assign xfer_n = bump(xfer_q, q_xfer);
  assign open_n = bump(open_q, q_open);
  assign byt_sum = {1'b0, byt_q} + (BYTE_W+1)'(mc_bytes);
  assign byt_n  = !q_xfer ? byt_q : (byt_sum[BYTE_W] ? BMAX : byt_sum[BYTE_W-1:0]);
  assign sat_n  = (idle_n < cfg_idle_thresh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tot_q <= '0; busy_q <= '0; xfer_q <= '0; open_q <= '0; idle_q <= '0; byt_q <= '0;
      sh_tot <= '0; sh_busy <= '0; sh_xfer <= '0; sh_open <= '0; sh_idle <= '0; sh_byt <= '0;
      sat_q <= 1'b0;
    end else if (win_done) begin
      sh_tot <= tot_n; sh_busy <= busy_n; sh_xfer <= xfer_n;
      sh_open <= open_n; sh_idle <= idle_n; sh_byt <= byt_n;
      sat_q <= sat_n;
      tot_q <= '0; busy_q <= '0; xfer_q <= '0; open_q <= '0; idle_q <= '0; byt_q <= '0;
    end else begin
      tot_q <= tot_n; busy_q <= busy_n; xfer_q <= xfer_n;
      open_q <= open_n; idle_q <= idle_n; byt_q <= byt_n;
    end
  end

  assign sat_flag = sat_q;

  always_comb begin
    case (rd_addr)
      3'd0: rd_data = BYTE_W'(win_done ? tot_n  : sh_tot);
      3'd1: rd_data = BYTE_W'(win_done ? busy_n : sh_busy);
      3'd2: rd_data = BYTE_W'(win_done ? xfer_n : sh_xfer);
      3'd3: rd_data = BYTE_W'(win_done ? open_n : sh_open);
      3'd4: rd_data = win_done ? byt_n : sh_byt;
      3'd5: rd_data = BYTE_W'(win_done ? idle_n : sh_idle);
      3'd6: rd_data = BYTE_W'(win_done ? sat_n  : sat_q);
      default: rd_data = '0;
    endcase
  end

  assert_window_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> sh_tot == $past(win_len));
  assert_xfer_le_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sh_xfer <= sh_busy);
  assert_open_le_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sh_open <= sh_busy);
  assert_idle_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, sh_busy} + {1'b0, sh_idle}) == {1'b0, sh_tot});
  assert_sat_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> sat_q == (sh_idle < $past(cfg_idle_thresh)));
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (byt_q == BMAX && !win_done) |=> byt_q == BMAX);

endmodule

// File: tb/tb_sdram_perf_monitor.sv
`timescale 1ns/1ps
module tb_sdram_perf_monitor;
  localparam int CW = 8, BW = 12, KW = 8;
  localparam int BMAX = 4095;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [CW-1:0] cfg_window, cfg_idle_thresh;
  logic mc_busy, mc_xfer, mc_open;
  logic [KW-1:0] mc_bytes;
  logic [2:0] rd_addr;
  logic [BW-1:0] rd_data;
  logic win_done, sat_flag;

  sdram_perf_monitor #(.CNT_W(CW), .BYTE_W(BW), .BEAT_W(KW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_window(cfg_window), .cfg_idle_thresh(cfg_idle_thresh),
    .mc_busy(mc_busy), .mc_xfer(mc_xfer), .mc_open(mc_open), .mc_bytes(mc_bytes),
    .rd_addr(rd_addr), .rd_data(rd_data), .win_done(win_done), .sat_flag(sat_flag));

  int n_chk = 0, n_bad = 0;

  // columns: window, busy cycles, data cycles, opens, bytes/beat, threshold, ghost strobes, expected sat
  localparam int NV = 7;
  localparam int VEC [NV][8] = '{
    '{10,  6,  4, 2,  16,  3, 0, 0},
    '{20, 19, 10, 5,  32,  2, 0, 1},
    '{ 1,  1,  1, 1,   8,  1, 0, 1},
    '{ 0,  0,  0, 0,   0,  1, 0, 0},
    '{12,  5,  5, 5, 200,  0, 1, 0},
    '{30, 30, 30, 1, 255,  5, 0, 1},
    '{40, 20,  8, 8,   1, 20, 0, 0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = 3'(a);
    #0.3;
    v = int'(rd_data);
  endtask

  task automatic do_reset(input int w, input int t);
    @(negedge clk);
    rst_n = 1'b0; cfg_window = CW'(w); cfg_idle_thresh = CW'(t);
    mc_busy = 0; mc_xfer = 0; mc_open = 0; mc_bytes = '0; rd_addr = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_window(input int w, input int b, input int d, input int a,
                            input int k, input int g);
    int wl;
    wl = (w == 0) ? 1 : w;
    for (int i = 0; i < wl; i++) begin
      if (i < b) begin
        mc_busy = 1; mc_xfer = (i < d); mc_open = (i < a);
      end else begin
        mc_busy = 0; mc_xfer = (g != 0); mc_open = (g != 0);
      end
      mc_bytes = mc_xfer ? KW'(k) : '0;
      rd_addr = 3'd0;
      #1;
      if (i == wl - 1) begin
        chk("R1 win_done in last cycle", int'(win_done), 1);
        chk("R10 bypass read of total", int'(rd_data), wl);
      end else if (i == 0) begin
        chk("R1 win_done low mid-window", int'(win_done), 0);
      end
      @(negedge clk);
    end
    mc_busy = 0; mc_xfer = 0; mc_open = 0; mc_bytes = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int v, wl, eb;
    rst_n = 0; cfg_window = '0; cfg_idle_thresh = '0;
    mc_busy = 0; mc_xfer = 0; mc_open = 0; mc_bytes = '0; rd_addr = '0;

    // R11 reset state
    do_reset(10, 0);
    #1;
    chk("R11 win_done after reset", int'(win_done), 0);
    chk("R11 sat_flag after reset", int'(sat_flag), 0);
    for (int r = 0; r < 8; r++) begin
      rd(r, v);
      chk($sformatf("R11 reg %0d after reset", r), v, 0);
    end

    // vector table
    for (int n = 0; n < NV; n++) begin
      do_reset(VEC[n][0], VEC[n][5]);
      run_window(VEC[n][0], VEC[n][1], VEC[n][2], VEC[n][3], VEC[n][4], VEC[n][6]);
      cfg_window = CW'(255);
      wl = (VEC[n][0] == 0) ? 1 : VEC[n][0];
      eb = VEC[n][2] * VEC[n][4];
      if (eb > BMAX) eb = BMAX;
      rd(0, v); chk($sformatf("R1 R12 total vec%0d", n), v, wl);
      rd(1, v); chk($sformatf("R2 busy vec%0d", n), v, VEC[n][1]);
      rd(2, v); chk($sformatf("R3 data cycles vec%0d", n), v, VEC[n][2]);
      rd(3, v); chk($sformatf("R4 page opens vec%0d", n), v, VEC[n][3]);
      rd(4, v); chk($sformatf("R5 R9 bytes vec%0d", n), v, eb);
      rd(5, v); chk($sformatf("R6 idle vec%0d", n), v, wl - VEC[n][1]);
      rd(6, v); chk($sformatf("R7 status vec%0d", n), v, VEC[n][7]);
      chk($sformatf("R7 sat_flag vec%0d", n), int'(sat_flag), VEC[n][7]);
      rd(7, v); chk($sformatf("R12 unused addr vec%0d", n), v, 0);
    end

    // R8 back-to-back windows: busy window then quiet window
    do_reset(5, 0);
    run_window(5, 5, 5, 2, 4, 0);
    rd(1, v); chk("R8 first window busy", v, 5);
    rd(4, v); chk("R8 first window bytes", v, 20);
    run_window(5, 0, 0, 0, 0, 0);
    cfg_window = CW'(255);
    rd(0, v); chk("R8 second window total", v, 5);
    rd(1, v); chk("R8 second window busy", v, 0);
    rd(2, v); chk("R8 second window data", v, 0);
    rd(3, v); chk("R8 second window opens", v, 0);
    rd(4, v); chk("R8 second window bytes", v, 0);
    rd(5, v); chk("R8 second window idle", v, 5);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule